// File: doc/BRIEF.md
# Serial Shift-Out Retimer for Daisy-Chained Converters

This block drives the serial data output of a 16-stage input shift register. A word is clocked in on `din`, most significant bit first, on rising `sclk` edges while `cs_n` is low. Each bit leaves on `dout` once it has passed through all 16 stages. Tying one device's `dout` to the next device's `din` builds a daisy chain in which all devices share a clock and a select. The same path lets a host read back the bits it shifted in.

The output can be taken in one of two ways. The first is straight from the last stage, which changes on the rising edge and gives a 16-cycle lag. The second is a copy of the last stage taken on the falling edge, which gives a 16.5-cycle lag. An external command decoder sets `late_edge` to pick the path.

While `shdn` is high, the shift register keeps accepting data but `dout` stays at the level it had when shutdown began. The full register contents are brought out on `word` for the neighbouring command decoder.

Top module: `shift_out_retimer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `word` is all zeros and `dout` is 0 until data is shifted in.
- R2: With `late_edge`=0 and `shdn`=0, `dout` changes just after a rising `sclk` edge. It equals the `din` bit sampled 16 shifting rising edges earlier, which is `word[15]`.
- R3: With `late_edge`=1 and `shdn`=0, `dout` changes just after a falling `sclk` edge. It takes the value `word[15]` has at that edge, so the bit appears half a clock later than in R2 (a 16.5-cycle lag). A change of `late_edge` switches the path at once.
- R4: While `shdn` is high, `dout` holds the value it had at the last falling edge before `shdn` rose, and `word` keeps shifting. When `shdn` falls, `dout` at once follows the path chosen by `late_edge`.
- R5: A rising edge with `cs_n` high does not shift. `word` is unchanged, and so is `dout` in the rising-edge mode.
- R6: `word[0]` holds the newest bit and `word[15]` the oldest, so a 16-bit value sent MSB first appears unchanged on `word`.
- R7: In a chain of three devices in the rising-edge mode, after 48 shifting edges the last device holds the first word sent, the middle device the second, and the first device the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; shifts on rising edge, retimes on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; shifting happens only while low |
| din | input | 1 | Serial data in, MSB first |
| late_edge | input | 1 | 0: output from last stage (16-cycle lag); 1: falling-edge copy (16.5-cycle lag) |
| shdn | input | 1 | Shutdown; freezes `dout` |
| dout | output | 1 | Serial data out toward the next device |
| word | output | 16 | Shift register contents, bit 15 oldest |

## Verification
In the rising-edge mode, a `dout` result is due just after the rising edge that moves a bit into the last stage. In the falling-edge mode, it is due after the following falling edge. `word` settles after every rising edge. The bench drives inputs 1 ns after each falling edge and samples 2 ns after every edge of either kind. A queue-based model predicts the value for that exact phase, so a half-cycle slip in either path shows up as a mismatch. The chain check reads each device's `word` after exactly 48 shifting edges.

// File: rtl/shift_out_retimer.sv
module shift_out_retimer #(
  parameter int W = 16
) (
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         din,
  input  logic         late_edge,
  input  logic         shdn,
  output logic         dout,
  output logic [W-1:0] word
);
  localparam int TOP = W - 1;

  logic [W-1:0] sr;
  logic         half_q;
  logic         hold_q;
  logic         live;

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n)     sr <= '0;
    else if (!cs_n) sr <= {sr[TOP-1:0], din};

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= sr[TOP];

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n)     hold_q <= 1'b0;
    else if (!shdn) hold_q <= sr[TOP];

  assign live = late_edge ? half_q : sr[TOP];
  assign dout = shdn ? hold_q : live;
  assign word = sr;

  // R2
  early_lag_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!late_edge && !shdn && $past(rst_n) && !$past(cs_n)) |-> dout == $past(word[TOP-1]));

  // R3
  late_path_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (late_edge && !shdn && $past(rst_n)) |-> dout == word[TOP]);

  // R4
  frozen_out_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (shdn && $past(shdn) && $past(rst_n)) |-> $stable(dout));

  // R5
  idle_word_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    ($past(cs_n) && $past(rst_n)) |-> $stable(word));
endmodule

// File: tb/shift_out_retimer_test.sv
module shift_out_retimer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, din = 1'b0, late = 1'b0, shdn = 1'b0;
  logic d0, d1, d2;
  logic [15:0] w0, w1, w2;
  int total = 0, bad = 0;
  bit run = 0;

  shift_out_retimer uut (.sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
    .late_edge(late), .shdn(shdn), .dout(d0), .word(w0));
  shift_out_retimer u1 (.sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(d0),
    .late_edge(late), .shdn(shdn), .dout(d1), .word(w1));
  shift_out_retimer u2 (.sclk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(d1),
    .late_edge(late), .shdn(shdn), .dout(d2), .word(w2));

  bit q[$];
  bit m_half = 0, m_hold = 0;

  initial for (int i = 0; i < 16; i++) q.push_back(1'b0);

  always @(posedge clk)
    if (rst_n && !cs_n) begin q.push_front(din); void'(q.pop_back()); end

  always @(negedge clk)
    if (!rst_n) begin m_half = 0; m_hold = 0; end
    else begin m_half = q[15]; if (!shdn) m_hold = q[15]; end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%h exp=%h", req, $time, got, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] ew;
    bit ed;
    for (int i = 0; i < 16; i++) ew[i] = q[i];
    ed = shdn ? m_hold : (late ? m_half : q[15]);
    check(shdn ? "R4" : (late ? "R3" : "R2"), {15'b0, d0}, {15'b0, ed});
    check(cs_n ? "R5" : "R6", w0, ew);
  endtask

  always @(posedge clk) begin #2; if (run) compare(); end
  always @(negedge clk) begin #2; if (run) compare(); end

  task automatic step(bit sel_n, bit b);
    @(negedge clk); #1; cs_n = sel_n; din = b;
  endtask

  task automatic send(logic [15:0] v);
    for (int i = 15; i >= 0; i--) step(1'b0, v[i]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", w0, 16'h0);
    check("R1", {15'b0, d0}, 16'h0);
    @(negedge clk); #1; rst_n = 1'b1;
    run = 1;
    @(posedge clk); #3;
    check("R1", w0, 16'h0);

    send(16'hA5C3); send(16'h1E0F); send(16'h6B92);
    idle(1);
    check("R7", w2, 16'hA5C3);
    check("R7", w1, 16'h1E0F);
    check("R7", w0, 16'h6B92);
    idle(5);

    @(negedge clk); #1; late = 1'b1;
    send(16'hF00D); send(16'h3C69);
    idle(3);

    send(16'h8421);
    @(negedge clk); #1; shdn = 1'b1; cs_n = 1'b0; din = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b0, i[0]);
    @(negedge clk); #1; late = 1'b0;
    send(16'hC0DE);
    @(negedge clk); #1; shdn = 1'b0;
    send(16'h5A5A);

    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1; late = i[1]; cs_n = 1'b0; din = i[0] ^ i[2];
    end
    idle(4);
    run = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule